// File: doc/BRIEF.md
# Receive FIFO with Error Tracking

This block sits between a serial receiver and a host. Each time the receiver finishes a character it pushes the data byte together with three per-character status bits: parity error, framing error and line-break detected. The host pops entries from the other side. The oldest stored entry, with its byte and its status bits, is always shown at the output.

Alongside the data path the block keeps one summary flag that says whether any entry still waiting in the queue carries an error of any kind. The host can test a single bit instead of scanning the queue. The flag drops only after the last erroneous entry has been read out.

A push that arrives while the queue is full is dropped and recorded in a sticky overrun flag. The host clears that flag with a status-read strobe.

Top module: `rx_err_fifo`

## Requirements
- R1: After synchronous reset, `empty` is 1 and `full`, `err_any` and `overrun` are all 0.
- R2: Entries leave in the order they were accepted. While `empty` is 0, `head_data` and `head_stat` show the oldest stored entry. The status layout is bit 0 = parity error, bit 1 = framing error, bit 2 = break.
- R3: `full` rises in the cycle after the DEPTH-th stored entry is accepted. A push while `full` is 1 is dropped and leaves the stored contents unchanged.
- R4: A pop while `empty` is 1 is ignored. The queue stays empty and no error state changes.
- R5: In the cycle after an entry with any nonzero status bit is accepted, `err_any` is 1.
- R6: `err_any` is 0 exactly when no stored entry has a nonzero status. It falls in the cycle after the last such entry is popped.
- R7: An accepted push and an accepted pop in the same cycle leave the fill level unchanged. Both of their effects are applied to the error tracking.
- R8: A push while `full` is 1 sets `overrun` in the next cycle. `overrun` then holds until a cycle with `stat_rd` high and no new overflow; it reads 0 in the following cycle. An overflow in the same cycle as `stat_rd` keeps the flag set.
- R9: Parity, framing and break errors each set `err_any` on their own, and the flag treats the three kinds the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Receiver delivers one entry |
| push_data | input | DATA_W | Received byte |
| push_stat | input | 3 | Status of the received byte {break, framing, parity} |
| pop | input | 1 | Host removes the head entry |
| stat_rd | input | 1 | Host status read; clears `overrun` |
| head_data | output | DATA_W | Byte of the oldest entry |
| head_stat | output | 3 | Status bits of the oldest entry |
| empty | output | 1 | No entries stored |
| full | output | 1 | DEPTH entries stored |
| err_any | output | 1 | At least one stored entry has an error |
| overrun | output | 1 | Sticky: a push was dropped while full |

## Verification
The bench builds the block at its defaults, DEPTH = 16 and DATA_W = 8. At that depth, filling the queue, overflowing it and draining it again takes only a few dozen cycles. Random traffic with frequent pushes therefore reaches the full boundary, overrun and simultaneous push/pop many times. Because the queue is shallow, the error-summary flag often has to stay up across several erroneous entries and then clear at exactly the right pop. The bench checks this against a flag computed by scanning its own model queue.

// File: rtl/rx_err_fifo_pkg.sv
package rx_err_fifo_pkg;
  localparam int STAT_W = 3;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_stat_t;
endpackage

// File: rtl/rx_fifo_ptrs.sv
module rx_fifo_ptrs #(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic             empty,
  output logic             full
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] wptr_q, rptr_q;

  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign wptr    = wptr_q;
  assign rptr    = rptr_q;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (push_ok) wptr_q <= wrap_inc(wptr_q);
      if (pop_ok)  rptr_q <= wrap_inc(rptr_q);
      empty <= (cnt_d == '0);
      full  <= (cnt_d == CNT_W'(DEPTH));
    end
  end
endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 11,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rx_err_track.sv
module rx_err_track #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic in_err,
  input  logic out_err,
  input  logic ovf_evt,
  input  logic stat_rd,
  output logic err_any,
  output logic overrun
);
  logic [CNT_W-1:0] ecnt_q, ecnt_d;

  always_comb begin
    case ({in_err, out_err})
      2'b10:   ecnt_d = ecnt_q + CNT_W'(1);
      2'b01:   ecnt_d = ecnt_q - CNT_W'(1);
      default: ecnt_d = ecnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt_q  <= '0;
      err_any <= 1'b0;
      overrun <= 1'b0;
    end else begin
      ecnt_q  <= ecnt_d;
      err_any <= (ecnt_d != '0);
      if (ovf_evt)      overrun <= 1'b1;
      else if (stat_rd) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_err_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [STAT_W-1:0] push_stat,
  input  logic              pop,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] head_data,
  output logic [STAT_W-1:0] head_stat,
  output logic              empty,
  output logic              full,
  output logic              err_any,
  output logic              overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENT_W = DATA_W + STAT_W;

  logic             push_ok, pop_ok;
  logic [PTR_W-1:0] wptr, rptr;
  logic [ENT_W-1:0] rd_ent;
  rx_stat_t         hstat;

  rx_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .wptr(wptr), .rptr(rptr), .empty(empty), .full(full)
  );

  rx_fifo_store #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_store (
    .clk(clk), .we(push_ok), .waddr(wptr), .wdata({push_stat, push_data}),
    .raddr(rptr), .rdata(rd_ent)
  );

  assign hstat     = rx_stat_t'(rd_ent[ENT_W-1 -: STAT_W]);
  assign head_stat = hstat;
  assign head_data = rd_ent[DATA_W-1:0];

  rx_err_track #(.DEPTH(DEPTH)) u_err (
    .clk(clk), .rst(rst),
    .in_err(push_ok && (push_stat != '0)),
    .out_err(pop_ok && (hstat.brk || hstat.frm || hstat.par)),
    .ovf_evt(push && full),
    .stat_rd(stat_rd),
    .err_any(err_any), .overrun(overrun)
  );
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk (
  input logic       clk,
  input logic       rst,
  input logic       push,
  input logic [2:0] push_stat,
  input logic       pop,
  input logic       stat_rd,
  input logic [2:0] head_stat,
  input logic       empty,
  input logic       full,
  input logic       err_any,
  input logic       overrun
);
  p_not_full_and_empty_r3: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
    full && !pop |=> full);
  p_pop_empty_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    empty && pop && !push |=> empty && !err_any);
  p_err_after_push_r5: assert property (@(posedge clk) disable iff (rst)
    push && !full && (push_stat != 3'b000) |=> err_any);
  p_err_needs_data_r6: assert property (@(posedge clk) disable iff (rst)
    err_any |-> !empty);
  p_head_err_flags_r6: assert property (@(posedge clk) disable iff (rst)
    !empty && (head_stat != 3'b000) |-> err_any);
  p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
    push && full |=> overrun);
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overrun && !stat_rd |=> overrun);
  p_ovr_clear_r8: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !(push && full) |=> !overrun);
endmodule

bind rx_err_fifo rx_err_fifo_chk u_chk (
  .clk(clk), .rst(rst), .push(push), .push_stat(push_stat), .pop(pop),
  .stat_rd(stat_rd), .head_stat(head_stat), .empty(empty), .full(full),
  .err_any(err_any), .overrun(overrun)
);

// File: tb/rx_err_fifo_test.sv
module rx_err_fifo_test;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              push = 1'b0, pop = 1'b0, stat_rd = 1'b0;
  logic [DATA_W-1:0] push_data = '0;
  logic [2:0]        push_stat = '0;
  logic [DATA_W-1:0] head_data;
  logic [2:0]        head_stat;
  logic              empty, full, err_any, overrun;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  logic [10:0] mq[$];
  logic        m_ovr = 1'b0;

  always #5 clk = ~clk;

  rx_err_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .push_stat(push_stat), .pop(pop), .stat_rd(stat_rd),
    .head_data(head_data), .head_stat(head_stat), .empty(empty),
    .full(full), .err_any(err_any), .overrun(overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic model_err();
    foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check_all();
    chk("R3 empty", 32'(empty), 32'(mq.size() == 0));
    chk("R3 full", 32'(full), 32'(mq.size() == DEPTH));
    chk("R6 err_any", 32'(err_any), 32'(model_err()));
    chk("R8 overrun", 32'(overrun), 32'(m_ovr));
    if (mq.size() != 0) begin
      chk("R2 head_data", 32'(head_data), 32'(mq[0][7:0]));
      chk("R2 head_stat", 32'(head_stat), 32'(mq[0][10:8]));
    end
  endtask

  // one clock: drive at negedge, update model, check 1ns after posedge
  task automatic cyc(input logic pu, input logic [7:0] d, input logic [2:0] s,
                     input logic po, input logic rd);
    bit was_full, was_empty;
    @(negedge clk);
    push = pu; push_data = d; push_stat = s; pop = po; stat_rd = rd;
    was_full  = (mq.size() == DEPTH);
    was_empty = (mq.size() == 0);
    @(posedge clk);
    if (po && !was_empty) void'(mq.pop_front());
    if (pu && !was_full) mq.push_back({s, d});
    if (pu && was_full) m_ovr = 1'b1;
    else if (rd) m_ovr = 1'b0;
    #1;
    check_all();
    @(negedge clk);
    push = 1'b0; pop = 1'b0; stat_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 err_any", 32'(err_any), 32'd0);
    chk("R1 overrun", 32'(overrun), 32'd0);

    // R4 pop on empty
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    chk("R4 still empty", 32'(empty), 32'd1);

    // R3 fill with clean bytes, then overflow
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 8'(i + 8'h40), 3'b000, 1'b0, 1'b0);
    chk("R3 full after DEPTH pushes", 32'(full), 32'd1);
    cyc(1'b1, 8'hEE, 3'b111, 1'b0, 1'b0);
    chk("R3 dropped push keeps err clear", 32'(err_any), 32'd0);
    chk("R8 overrun set", 32'(overrun), 32'd1);
    cyc(1'b0, 8'h00, 3'b000, 1'b0, 1'b0);
    chk("R8 overrun sticky", 32'(overrun), 32'd1);
    cyc(1'b1, 8'hEF, 3'b000, 1'b0, 1'b1);
    chk("R8 overflow beats clear", 32'(overrun), 32'd1);
    cyc(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    chk("R8 overrun cleared", 32'(overrun), 32'd0);
    for (int i = 0; i < DEPTH; i++) cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    chk("R2 drained", 32'(empty), 32'd1);

    // R9 each error kind alone sets and clears the flag
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 8'(8'h10 + k), 3'(1 << k), 1'b0, 1'b0);
      chk("R9 single kind sets err_any", 32'(err_any), 32'd1);
      cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
      chk("R9 single kind clears", 32'(err_any), 32'd0);
    end

    // R5/R6 error stays while any erroneous entry remains
    cyc(1'b1, 8'hA1, 3'b001, 1'b0, 1'b0);
    chk("R5 err after push", 32'(err_any), 32'd1);
    cyc(1'b1, 8'hA2, 3'b000, 1'b0, 1'b0);
    cyc(1'b1, 8'hA3, 3'b100, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    chk("R6 err held by later entry", 32'(err_any), 32'd1);
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    chk("R6 err held", 32'(err_any), 32'd1);
    // R7 pop erroneous head and push clean in same cycle
    cyc(1'b1, 8'hA4, 3'b000, 1'b1, 1'b0);
    chk("R7 err cleared on swap", 32'(err_any), 32'd0);
    chk("R7 level unchanged", 32'(mq.size()), 32'd1);
    // R7 pop clean head and push erroneous in same cycle
    cyc(1'b1, 8'hA5, 3'b010, 1'b1, 1'b0);
    chk("R7 err set on swap", 32'(err_any), 32'd1);
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    chk("R6 err falls with last entry", 32'(err_any), 32'd0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] s;
      s = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
      cyc(($urandom_range(0, 9) < 6), 8'($urandom), s,
          ($urandom_range(0, 9) < 5), ($urandom_range(0, 7) == 0));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule